// File: doc/BRIEF.md
# Halfword and Doubleword Load/Store Address Unit

This unit runs one family of load/store instructions: unsigned halfword store and load, signed byte load, signed halfword load, and doubleword load and store across an even/odd register pair. Each instruction gives a 4-bit opcode group and a 5-bit mode field. From these the unit works out the offset source, the direction of the offset, where the indexing happens, whether the base is written back, and which of the group's two operations runs.

When an instruction is accepted, the unit reads its operands through a four-lane register-read port in the same cycle. It then issues one memory request with a handshake and waits for the response. After the response it returns results through a single register write port, one register per cycle. While it holds an instruction it raises `busy` and takes no other instruction. An encoding that is not valid raises a one-cycle undefined-instruction pulse and touches neither memory nor registers.

Top module: `halfdbl_lsu`

## Requirements
- R1: Mode bit 4 (pre) picks the indexing. With pre=1 the request address is base±offset. With pre=0 the request address is the unmodified base.
- R2: Mode bit 3 (up) set adds the offset to the base and clear subtracts it, modulo 2^DW.
- R3: Mode bit 2 (imm) set makes the offset the 8-bit value {instImmHi, instImmLo}, zero-extended. Clear takes the offset from the register named by instRm.
- R4: The base register instRn gets base±offset whenever pre=0, and when pre=1 only if mode bit 1 (wb) is set. This write is the last writeback cycle of the instruction.
- R5: In group 0xB, mode bit 0 (ld) clear stores the low 16 bits of register instRd as a halfword. Set loads a zero-extended halfword into instRd.
- R6: In group 0xD, ld clear loads a doubleword with one request. Data bits 31:0 go to the even register (instRd with bit 0 cleared) and bits 63:32 go to the odd register (bit 0 set). ld set loads a sign-extended byte into instRd.
- R7: In group 0xF, ld clear stores the doubleword {odd register, even register}, odd in the upper half. ld set loads a sign-extended halfword into instRd.
- R8: Any group other than 0xB, 0xD or 0xF, and any mode with pre=0 and wb=1, gives undefInst high for exactly the cycle after acceptance, with no memory request and no register write.
- R9: memReqValid rises the cycle after acceptance. It stays high with address, size, direction and write data unchanged until memReqReady is seen.
- R10: busy is high from the cycle after acceptance until the last writeback cycle ends. While busy, instValid is ignored.
- R11: If a load writes the base register, the loaded data is kept and the base writeback is dropped.
- R12: Register writes start the cycle after memRspValid and take one per cycle back to back, in this order: even (or single) data, then odd data, then base.
- R13: memReqSize is 0 for a byte, 1 for a halfword and 3 for a doubleword. Store data is right-aligned with unused upper bits zero, and load data is taken from the low end of memRspData.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| instValid | input | 1 | Instruction offered |
| instGroup | input | 4 | Opcode group |
| instMode | input | 5 | {pre, up, imm, wb, ld} |
| instImmHi | input | 4 | Immediate high nibble |
| instImmLo | input | 4 | Immediate low nibble |
| instRd | input | RIW | Data register index |
| instRn | input | RIW | Base register index |
| instRm | input | RIW | Offset register index |
| busy | output | 1 | Instruction in progress |
| rfBaseAddr | output | RIW | Read lane: base index |
| rfBaseData | input | DW | Read lane: base value |
| rfOffAddr | output | RIW | Read lane: offset index |
| rfOffData | input | DW | Read lane: offset value |
| rfLoAddr | output | RIW | Read lane: data/even index |
| rfLoData | input | DW | Read lane: data/even value |
| rfHiAddr | output | RIW | Read lane: odd index |
| rfHiData | input | DW | Read lane: odd value |
| memReqValid | output | 1 | Memory request valid |
| memReqReady | input | 1 | Memory request taken |
| memReqWrite | output | 1 | 1 = store |
| memReqSize | output | 2 | Transfer size code |
| memReqAddr | output | DW | Request address |
| memReqWdata | output | 2*DW | Store data |
| memRspValid | input | 1 | Response valid |
| memRspData | input | 2*DW | Response data |
| undefInst | output | 1 | Undefined encoding pulse |
| wbEn | output | 1 | Register write enable |
| wbAddr | output | RIW | Register write index |
| wbData | output | DW | Register write value |

## Verification
The properties assume that memRspValid arrives only after the request has been taken and only once per request. They also assume that the read-port data matches the lane addresses in the acceptance cycle. The stimulus drives every response from a task that waits for the request handshake before pulsing memRspValid for a single cycle. A bench register file answers each read lane combinationally. In some runs instValid stays high with unrelated fields for the whole busy window, which checks that nothing outside the acceptance cycle leaks in.

// File: rtl/halfdbl_lsu_pkg.sv
package halfdbl_lsu_pkg;

  localparam logic [3:0] GRP_HALF   = 4'hB;
  localparam logic [3:0] GRP_DBL_SB = 4'hD;
  localparam logic [3:0] GRP_DBL_SH = 4'hF;

  localparam int MB_PRE = 4;
  localparam int MB_UP  = 3;
  localparam int MB_IMM = 2;
  localparam int MB_WB  = 1;
  localparam int MB_LD  = 0;

  localparam logic [1:0] SZ_BYTE  = 2'd0;
  localparam logic [1:0] SZ_HALF  = 2'd1;
  localparam logic [1:0] SZ_DWORD = 2'd3;

  typedef enum logic [2:0] {
    OP_STH, OP_LDH, OP_LDD, OP_LDSB, OP_STD, OP_LDSH, OP_BAD
  } xferOp_e;

  typedef enum logic [1:0] {WB_LO, WB_HI, WB_BASE} wbSel_e;

  typedef struct packed {
    logic undef;
    logic isLoad;
    logic isDouble;
    logic doBase;
  } decFlags_t;

  typedef struct packed {
    logic   capInst;
    logic   capRsp;
    logic   wbEn;
    wbSel_e wbSel;
  } dpStrobe_t;

endpackage

// File: rtl/halfdbl_lsu_decode.sv
module halfdbl_lsu_decode
  import halfdbl_lsu_pkg::*;
#(
  parameter int DW  = 32,
  parameter int RIW = 4
) (
  input  logic [3:0]      grp,
  input  logic [4:0]      mode,
  input  logic [3:0]      immHi,
  input  logic [3:0]      immLo,
  input  logic [RIW-1:0]  rdIdx,
  input  logic [RIW-1:0]  rnIdx,
  input  logic [DW-1:0]   baseVal,
  input  logic [DW-1:0]   offRegVal,
  input  logic [DW-1:0]   loVal,
  input  logic [DW-1:0]   hiVal,
  output decFlags_t       flags,
  output xferOp_e         op,
  output logic [DW-1:0]   reqAddr,
  output logic [DW-1:0]   newBase,
  output logic [1:0]      reqSize,
  output logic            reqWrite,
  output logic [2*DW-1:0] reqWdata,
  output logic [RIW-1:0]  loIdx,
  output logic [RIW-1:0]  hiIdx
);
  localparam int MW = 2 * DW;

  logic preBit, upBit, immBit, wbBit, ldBit;
  logic [DW-1:0] offset;
  logic [DW-1:0] indexed;
  logic baseWb, isLoad, isDouble, collide, badGroup;

  assign preBit = mode[MB_PRE];
  assign upBit  = mode[MB_UP];
  assign immBit = mode[MB_IMM];
  assign wbBit  = mode[MB_WB];
  assign ldBit  = mode[MB_LD];

  always_comb begin
    unique case (grp)
      GRP_HALF:   op = ldBit ? OP_LDH  : OP_STH;
      GRP_DBL_SB: op = ldBit ? OP_LDSB : OP_LDD;
      GRP_DBL_SH: op = ldBit ? OP_LDSH : OP_STD;
      default:    op = OP_BAD;
    endcase
  end

  assign badGroup = (op == OP_BAD);
  assign offset   = immBit ? {{(DW-8){1'b0}}, immHi, immLo} : offRegVal;
  assign indexed  = upBit ? (baseVal + offset) : (baseVal - offset);
  assign reqAddr  = preBit ? indexed : baseVal;
  assign newBase  = indexed;
  assign baseWb   = !preBit || wbBit;

  assign isDouble = (op == OP_LDD) || (op == OP_STD);
  assign isLoad   = (op == OP_LDH) || (op == OP_LDD) || (op == OP_LDSB) || (op == OP_LDSH);
  assign reqWrite = (op == OP_STH) || (op == OP_STD);

  assign loIdx = isDouble ? {rdIdx[RIW-1:1], 1'b0} : rdIdx;
  assign hiIdx = {rdIdx[RIW-1:1], 1'b1};

  assign collide = isLoad && ((rnIdx == loIdx) || (isDouble && rnIdx == hiIdx));

  always_comb begin
    unique case (op)
      OP_LDSB:               reqSize = SZ_BYTE;
      OP_STH, OP_LDH, OP_LDSH: reqSize = SZ_HALF;
      OP_LDD, OP_STD:        reqSize = SZ_DWORD;
      default:               reqSize = SZ_BYTE;
    endcase
  end

  always_comb begin
    unique case (op)
      OP_STH:  reqWdata = {{(MW-16){1'b0}}, loVal[15:0]};
      OP_STD:  reqWdata = {hiVal, loVal};
      default: reqWdata = '0;
    endcase
  end

  assign flags.undef    = badGroup || (!preBit && wbBit);
  assign flags.isLoad   = isLoad;
  assign flags.isDouble = isDouble;
  assign flags.doBase   = baseWb && !collide;

endmodule

// File: rtl/halfdbl_lsu_ctrl.sv
module halfdbl_lsu_ctrl
  import halfdbl_lsu_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      instValid,
  input  decFlags_t flagsIn,
  input  logic      memReqReady,
  input  logic      memRspValid,
  output dpStrobe_t strobe,
  output logic      busy,
  output logic      memReqValid,
  output logic      undefInst
);
  typedef enum logic [2:0] {
    ST_IDLE, ST_REQ, ST_WAIT, ST_UNDEF, ST_WRLO, ST_WRHI, ST_WRBASE
  } state_e;

  state_e state, stateNxt;
  logic   ldQ, dblQ, baseQ;
  logic   accept;

  assign accept = instValid && (state == ST_IDLE);

  always_comb begin
    stateNxt = state;
    unique case (state)
      ST_IDLE:   if (accept) stateNxt = flagsIn.undef ? ST_UNDEF : ST_REQ;
      ST_REQ:    if (memReqReady) stateNxt = ST_WAIT;
      ST_WAIT:   if (memRspValid) begin
                   if (ldQ)        stateNxt = ST_WRLO;
                   else if (baseQ) stateNxt = ST_WRBASE;
                   else            stateNxt = ST_IDLE;
                 end
      ST_UNDEF:  stateNxt = ST_IDLE;
      ST_WRLO:   stateNxt = dblQ ? ST_WRHI : (baseQ ? ST_WRBASE : ST_IDLE);
      ST_WRHI:   stateNxt = baseQ ? ST_WRBASE : ST_IDLE;
      ST_WRBASE: stateNxt = ST_IDLE;
      default:   stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      ldQ   <= 1'b0;
      dblQ  <= 1'b0;
      baseQ <= 1'b0;
    end else begin
      state <= stateNxt;
      if (accept) begin
        ldQ   <= flagsIn.isLoad;
        dblQ  <= flagsIn.isDouble;
        baseQ <= flagsIn.doBase;
      end
    end
  end

  assign busy        = (state != ST_IDLE);
  assign memReqValid = (state == ST_REQ);
  assign undefInst   = (state == ST_UNDEF);

  always_comb begin
    strobe.capInst = accept;
    strobe.capRsp  = (state == ST_WAIT) && memRspValid;
    strobe.wbEn    = (state == ST_WRLO) || (state == ST_WRHI) || (state == ST_WRBASE);
    unique case (state)
      ST_WRHI:   strobe.wbSel = WB_HI;
      ST_WRBASE: strobe.wbSel = WB_BASE;
      default:   strobe.wbSel = WB_LO;
    endcase
  end

endmodule

// File: rtl/halfdbl_lsu_dp.sv
module halfdbl_lsu_dp
  import halfdbl_lsu_pkg::*;
#(
  parameter int DW  = 32,
  parameter int RIW = 4
) (
  input  logic            clk,
  input  logic            rstN,
  input  dpStrobe_t       strobe,
  input  xferOp_e         opIn,
  input  logic [DW-1:0]   reqAddrIn,
  input  logic [DW-1:0]   newBaseIn,
  input  logic [1:0]      reqSizeIn,
  input  logic            reqWriteIn,
  input  logic [2*DW-1:0] reqWdataIn,
  input  logic [RIW-1:0]  rnIn,
  input  logic [RIW-1:0]  loIdxIn,
  input  logic [RIW-1:0]  hiIdxIn,
  input  logic [2*DW-1:0] rspData,
  output logic [DW-1:0]   memReqAddr,
  output logic [1:0]      memReqSize,
  output logic            memReqWrite,
  output logic [2*DW-1:0] memReqWdata,
  output logic [RIW-1:0]  wbAddr,
  output logic [DW-1:0]   wbData
);
  xferOp_e         opQ;
  logic [DW-1:0]   newBaseQ;
  logic [RIW-1:0]  rnQ, loQ, hiQ;
  logic [2*DW-1:0] rspQ;
  logic [DW-1:0]   loadVal;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      opQ         <= OP_BAD;
      memReqAddr  <= '0;
      memReqSize  <= '0;
      memReqWrite <= 1'b0;
      memReqWdata <= '0;
      newBaseQ    <= '0;
      rnQ         <= '0;
      loQ         <= '0;
      hiQ         <= '0;
      rspQ        <= '0;
    end else begin
      if (strobe.capInst) begin
        opQ         <= opIn;
        memReqAddr  <= reqAddrIn;
        memReqSize  <= reqSizeIn;
        memReqWrite <= reqWriteIn;
        memReqWdata <= reqWdataIn;
        newBaseQ    <= newBaseIn;
        rnQ         <= rnIn;
        loQ         <= loIdxIn;
        hiQ         <= hiIdxIn;
      end
      if (strobe.capRsp) rspQ <= rspData;
    end
  end

  always_comb begin
    unique case (opQ)
      OP_LDH:  loadVal = {{(DW-16){1'b0}}, rspQ[15:0]};
      OP_LDSB: loadVal = {{(DW-8){rspQ[7]}}, rspQ[7:0]};
      OP_LDSH: loadVal = {{(DW-16){rspQ[15]}}, rspQ[15:0]};
      default: loadVal = rspQ[DW-1:0];
    endcase
  end

  always_comb begin
    unique case (strobe.wbSel)
      WB_HI: begin
        wbAddr = hiQ;
        wbData = rspQ[2*DW-1:DW];
      end
      WB_BASE: begin
        wbAddr = rnQ;
        wbData = newBaseQ;
      end
      default: begin
        wbAddr = loQ;
        wbData = loadVal;
      end
    endcase
  end

endmodule

// File: rtl/halfdbl_lsu.sv
module halfdbl_lsu
  import halfdbl_lsu_pkg::*;
#(
  parameter int DW  = 32,
  parameter int RIW = 4
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            instValid,
  input  logic [3:0]      instGroup,
  input  logic [4:0]      instMode,
  input  logic [3:0]      instImmHi,
  input  logic [3:0]      instImmLo,
  input  logic [RIW-1:0]  instRd,
  input  logic [RIW-1:0]  instRn,
  input  logic [RIW-1:0]  instRm,
  output logic            busy,
  output logic [RIW-1:0]  rfBaseAddr,
  input  logic [DW-1:0]   rfBaseData,
  output logic [RIW-1:0]  rfOffAddr,
  input  logic [DW-1:0]   rfOffData,
  output logic [RIW-1:0]  rfLoAddr,
  input  logic [DW-1:0]   rfLoData,
  output logic [RIW-1:0]  rfHiAddr,
  input  logic [DW-1:0]   rfHiData,
  output logic            memReqValid,
  input  logic            memReqReady,
  output logic            memReqWrite,
  output logic [1:0]      memReqSize,
  output logic [DW-1:0]   memReqAddr,
  output logic [2*DW-1:0] memReqWdata,
  input  logic            memRspValid,
  input  logic [2*DW-1:0] memRspData,
  output logic            undefInst,
  output logic            wbEn,
  output logic [RIW-1:0]  wbAddr,
  output logic [DW-1:0]   wbData
);
  decFlags_t       decFlags;
  dpStrobe_t       strobe;
  xferOp_e         decOp;
  logic [DW-1:0]   decAddr, decNewBase;
  logic [1:0]      decSize;
  logic            decWrite;
  logic [2*DW-1:0] decWdata;
  logic [RIW-1:0]  decLo, decHi;

  assign rfBaseAddr = instRn;
  assign rfOffAddr  = instRm;
  assign rfLoAddr   = decLo;
  assign rfHiAddr   = decHi;

  halfdbl_lsu_decode #(.DW(DW), .RIW(RIW)) uDecode (
    .grp(instGroup), .mode(instMode), .immHi(instImmHi), .immLo(instImmLo),
    .rdIdx(instRd), .rnIdx(instRn), .baseVal(rfBaseData), .offRegVal(rfOffData),
    .loVal(rfLoData), .hiVal(rfHiData), .flags(decFlags), .op(decOp),
    .reqAddr(decAddr), .newBase(decNewBase), .reqSize(decSize), .reqWrite(decWrite),
    .reqWdata(decWdata), .loIdx(decLo), .hiIdx(decHi)
  );

  halfdbl_lsu_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .instValid(instValid), .flagsIn(decFlags),
    .memReqReady(memReqReady), .memRspValid(memRspValid), .strobe(strobe),
    .busy(busy), .memReqValid(memReqValid), .undefInst(undefInst)
  );

  halfdbl_lsu_dp #(.DW(DW), .RIW(RIW)) uDp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .opIn(decOp), .reqAddrIn(decAddr),
    .newBaseIn(decNewBase), .reqSizeIn(decSize), .reqWriteIn(decWrite),
    .reqWdataIn(decWdata), .rnIn(instRn), .loIdxIn(decLo), .hiIdxIn(decHi),
    .rspData(memRspData), .memReqAddr(memReqAddr), .memReqSize(memReqSize),
    .memReqWrite(memReqWrite), .memReqWdata(memReqWdata), .wbAddr(wbAddr),
    .wbData(wbData)
  );

  assign wbEn = strobe.wbEn;

endmodule

// File: rtl/halfdbl_lsu_chk.sv
module halfdbl_lsu_chk #(
  parameter int DW  = 32,
  parameter int RIW = 4
) (
  input logic            clk,
  input logic            rstN,
  input logic            instValid,
  input logic            busy,
  input logic            memReqValid,
  input logic            memReqReady,
  input logic            memReqWrite,
  input logic [1:0]      memReqSize,
  input logic [DW-1:0]   memReqAddr,
  input logic [2*DW-1:0] memReqWdata,
  input logic            undefInst,
  input logic            wbEn,
  input logic [RIW-1:0]  wbAddr
);
  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (!memReqValid && !wbEn && !undefInst));

  assert_accept_busy_R10: assert property (@(posedge clk) disable iff (!rstN)
    (instValid && !busy) |=> busy);

  assert_req_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    (memReqValid && !memReqReady) |=> (memReqValid && $stable(memReqAddr)
      && $stable(memReqWdata) && $stable(memReqSize) && $stable(memReqWrite)));

  assert_undef_pulse_R8: assert property (@(posedge clk) disable iff (!rstN)
    undefInst |=> (!undefInst && !busy));

  assert_undef_quiet_R8: assert property (@(posedge clk) disable iff (!rstN)
    undefInst |-> (!memReqValid && !wbEn));

  assert_size_code_R13: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid |-> (memReqSize != 2'd2));

  assert_req_before_wb_R12: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid |-> !wbEn);

  assert_wb_known_R12: assert property (@(posedge clk) disable iff (!rstN)
    wbEn |-> !$isunknown(wbAddr));
endmodule

bind halfdbl_lsu halfdbl_lsu_chk #(.DW(DW), .RIW(RIW)) uChk (
  .clk(clk), .rstN(rstN), .instValid(instValid), .busy(busy),
  .memReqValid(memReqValid), .memReqReady(memReqReady), .memReqWrite(memReqWrite),
  .memReqSize(memReqSize), .memReqAddr(memReqAddr), .memReqWdata(memReqWdata),
  .undefInst(undefInst), .wbEn(wbEn), .wbAddr(wbAddr)
);

// File: tb/tb_halfdbl_lsu.sv
`timescale 1ns/1ps
module tb_halfdbl_lsu;
  localparam int DW = 32;
  localparam int RIW = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic instValid = 1'b0;
  logic [3:0] instGroup = '0, instImmHi = '0, instImmLo = '0;
  logic [4:0] instMode = '0;
  logic [RIW-1:0] instRd = '0, instRn = '0, instRm = '0;
  logic busy, memReqValid, memReqWrite, undefInst, wbEn;
  logic memReqReady = 1'b0, memRspValid = 1'b0;
  logic [63:0] memRspData = '0;
  logic [1:0] memReqSize;
  logic [31:0] memReqAddr, wbData;
  logic [63:0] memReqWdata;
  logic [RIW-1:0] rfBaseAddr, rfOffAddr, rfLoAddr, rfHiAddr, wbAddr;
  logic [31:0] rfBaseData, rfOffData, rfLoData, rfHiData;
  logic [31:0] regs [16];

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  assign rfBaseData = regs[rfBaseAddr];
  assign rfOffData  = regs[rfOffAddr];
  assign rfLoData   = regs[rfLoAddr];
  assign rfHiData   = regs[rfHiAddr];

  halfdbl_lsu #(.DW(DW), .RIW(RIW)) dut (
    .clk(clk), .rstN(rstN), .instValid(instValid), .instGroup(instGroup),
    .instMode(instMode), .instImmHi(instImmHi), .instImmLo(instImmLo),
    .instRd(instRd), .instRn(instRn), .instRm(instRm), .busy(busy),
    .rfBaseAddr(rfBaseAddr), .rfBaseData(rfBaseData), .rfOffAddr(rfOffAddr),
    .rfOffData(rfOffData), .rfLoAddr(rfLoAddr), .rfLoData(rfLoData),
    .rfHiAddr(rfHiAddr), .rfHiData(rfHiData), .memReqValid(memReqValid),
    .memReqReady(memReqReady), .memReqWrite(memReqWrite), .memReqSize(memReqSize),
    .memReqAddr(memReqAddr), .memReqWdata(memReqWdata), .memRspValid(memRspValid),
    .memRspData(memRspData), .undefInst(undefInst), .wbEn(wbEn), .wbAddr(wbAddr),
    .wbData(wbData)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic idleChk(input string tag);
    chk(busy === 1'b0, {tag, " R10 busy"}, 64'(busy), 64'd0);
    chk(memReqValid === 1'b0 && wbEn === 1'b0 && undefInst === 1'b0,
        {tag, " R10 quiet"}, {61'd0, memReqValid, wbEn, undefInst}, 64'd0);
  endtask

  // Issues one instruction and follows it cycle by cycle against a behavioural model.
  task automatic runInst(input logic [3:0] grp, input logic [4:0] mode,
                         input logic [3:0] hi, input logic [3:0] lo,
                         input logic [3:0] rd, input logic [3:0] rn, input logic [3:0] rm,
                         input int reqWait, input int rspWait,
                         input logic [63:0] rsp, input bit pester);
    bit p, u, im, w, l, legal, baseWb, collide, isWr;
    int kind;
    string gtag;
    logic [31:0] base, off, sum, ea;
    logic [3:0] ev, od;
    logic [1:0] size;
    logic [63:0] wd;
    logic [3:0] qa[$];
    logic [31:0] qd[$];
    p = mode[4]; u = mode[3]; im = mode[2]; w = mode[1]; l = mode[0];
    base = regs[rn];
    off = im ? {24'd0, hi, lo} : regs[rm];
    sum = u ? base + off : base - off;
    ea = p ? sum : base;
    baseWb = !p || w;
    legal = (grp == 4'hB || grp == 4'hD || grp == 4'hF) && !(!p && w);
    ev = {rd[3:1], 1'b0};
    od = {rd[3:1], 1'b1};
    kind = (grp == 4'hB) ? (l ? 1 : 0) : (grp == 4'hD) ? (l ? 3 : 2) : (l ? 5 : 4);
    gtag = (kind < 2) ? "R5" : (kind < 4) ? "R6" : "R7";
    isWr = (kind == 0 || kind == 4);
    size = (kind == 3) ? 2'd0 : (kind == 2 || kind == 4) ? 2'd3 : 2'd1;
    wd = (kind == 0) ? {48'd0, regs[rd][15:0]} : (kind == 4) ? {regs[od], regs[ev]} : 64'd0;
    case (kind)
      1: begin qa.push_back(rd); qd.push_back({16'd0, rsp[15:0]}); end
      2: begin qa.push_back(ev); qd.push_back(rsp[31:0]); qa.push_back(od); qd.push_back(rsp[63:32]); end
      3: begin qa.push_back(rd); qd.push_back(32'($signed(rsp[7:0]))); end
      5: begin qa.push_back(rd); qd.push_back(32'($signed(rsp[15:0]))); end
      default: ;
    endcase
    collide = 1'b0;
    foreach (qa[k]) if (qa[k] == rn) collide = 1'b1;
    if (baseWb && !collide) begin qa.push_back(rn); qd.push_back(sum); end

    @(negedge clk);
    idleChk("pre-accept");
    instValid = 1'b1; instGroup = grp; instMode = mode; instImmHi = hi; instImmLo = lo;
    instRd = rd; instRn = rn; instRm = rm;
    @(negedge clk);
    if (pester) begin
      instGroup = 4'hD; instMode = 5'b11011; instImmHi = 4'hF; instImmLo = 4'hF;
      instRd = 4'd9; instRn = 4'd3; instRm = 4'd7;
    end else instValid = 1'b0;
    chk(busy === 1'b1, "R10 busy after accept", 64'(busy), 64'd1);
    if (!legal) begin
      chk(undefInst === 1'b1, "R8 undef pulse", 64'(undefInst), 64'd1);
      chk(memReqValid === 1'b0 && wbEn === 1'b0, "R8 no side effect",
          {62'd0, memReqValid, wbEn}, 64'd0);
      @(negedge clk);
      instValid = 1'b0;
      chk(undefInst === 1'b0, "R8 undef one cycle", 64'(undefInst), 64'd0);
      idleChk("R8 after undef");
      return;
    end
    for (int c = 0; c <= reqWait; c++) begin
      chk(memReqValid === 1'b1, "R9 request valid", 64'(memReqValid), 64'd1);
      chk(memReqAddr === ea, "R1/R2/R3 address", 64'(memReqAddr), 64'(ea));
      chk(memReqWrite === isWr, {gtag, " direction"}, 64'(memReqWrite), 64'(isWr));
      chk(memReqSize === size, "R13 size", 64'(memReqSize), 64'(size));
      chk(memReqWdata === wd, {gtag, " R13 store data"}, memReqWdata, wd);
      chk(wbEn === 1'b0 && undefInst === 1'b0, "R12 no write during request",
          {62'd0, wbEn, undefInst}, 64'd0);
      if (c == reqWait) memReqReady = 1'b1;
      @(negedge clk);
      memReqReady = 1'b0;
    end
    for (int c = 0; c <= rspWait; c++) begin
      chk(memReqValid === 1'b0 && wbEn === 1'b0, "R9 wait quiet",
          {62'd0, memReqValid, wbEn}, 64'd0);
      chk(busy === 1'b1, "R10 busy while waiting", 64'(busy), 64'd1);
      if (c == rspWait) begin memRspValid = 1'b1; memRspData = rsp; end
      @(negedge clk);
      memRspValid = 1'b0; memRspData = 64'hDEAD_BEEF_0BAD_F00D;
    end
    while (qa.size() > 0) begin
      logic [3:0] ea4;
      logic [31:0] ed;
      ea4 = qa.pop_front(); ed = qd.pop_front();
      chk(wbEn === 1'b1, "R12 write slot", 64'(wbEn), 64'd1);
      chk(wbAddr === ea4, {gtag, " R4 R11 R12 write index"}, 64'(wbAddr), 64'(ea4));
      chk(wbData === ed, {gtag, " R4 write value"}, 64'(wbData), 64'(ed));
      chk(busy === 1'b1, "R10 busy in writeback", 64'(busy), 64'd1);
      regs[ea4] = ed;
      @(negedge clk);
    end
    instValid = 1'b0;
    idleChk("R4 R11 R12 done");
  endtask

  initial begin
    for (int k = 0; k < 16; k++) regs[k] = 32'h1000_0000 + 32'(k) * 32'h0001_0110;
    regs[2] = 32'h0000_0004;
    regs[6] = 32'h0000_0040;
    repeat (3) @(negedge clk);
    idleChk("R10 reset");
    rstN = 1'b1;
    // halfword store, post-indexed, subtract register offset
    runInst(4'hB, 5'b00000, 4'h0, 4'h0, 4'd1, 4'd3, 4'd2, 0, 0, 64'd0, 1'b0);
    // halfword store, pre-indexed immediate add, no writeback, held request
    runInst(4'hB, 5'b11100, 4'h3, 4'hC, 4'd5, 4'd4, 4'd0, 3, 2, 64'd0, 1'b0);
    // unsigned halfword load, pre subtract register, writeback
    runInst(4'hB, 5'b10011, 4'h0, 4'h0, 4'd7, 4'd8, 4'd6, 1, 0, 64'h1111_2222_3333_F00D, 1'b0);
    // doubleword load, pre add register, no writeback, odd rd index
    runInst(4'hD, 5'b11000, 4'h0, 4'h0, 4'd5, 4'd10, 4'd2, 0, 1, 64'hCAFE_0001_BEEF_0002, 1'b0);
    // signed byte load, post subtract immediate
    runInst(4'hD, 5'b00101, 4'h1, 4'h0, 4'd9, 4'd11, 4'd0, 0, 0, 64'h0000_0000_0000_0085, 1'b0);
    // doubleword store, post add immediate
    runInst(4'hF, 5'b01100, 4'h0, 4'h8, 4'd12, 4'd1, 4'd0, 2, 0, 64'd0, 1'b0);
    // signed halfword load, pre add immediate, writeback, instValid held during busy
    runInst(4'hF, 5'b11111, 4'hF, 4'hF, 4'd13, 4'd14, 4'd0, 1, 3, 64'h0000_0000_0000_8001, 1'b1);
    // undefined: post-indexed with writeback bit
    runInst(4'hB, 5'b00010, 4'h0, 4'h0, 4'd1, 4'd2, 4'd3, 0, 0, 64'd0, 1'b0);
    // undefined: group outside the family, with instValid held
    runInst(4'h9, 5'b10000, 4'h0, 4'h0, 4'd1, 4'd2, 4'd3, 0, 0, 64'd0, 1'b1);
    // load into the base register: data wins
    runInst(4'hB, 5'b01001, 4'h0, 4'h0, 4'd4, 4'd4, 4'd2, 0, 0, 64'h0000_0000_0000_7777, 1'b0);
    // doubleword load whose odd register is the base
    runInst(4'hD, 5'b00100, 4'h0, 4'h4, 4'd6, 4'd7, 4'd0, 0, 0, 64'h0123_4567_89AB_CDEF, 1'b0);
    // subtraction wrap below zero
    runInst(4'hB, 5'b00001, 4'h0, 4'h0, 4'd0, 4'd2, 4'd6, 0, 0, 64'h0000_0000_0000_00FF, 1'b0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule